// File: doc/BRIEF.md
# Multi-Source System Reset Sequencer

This block merges every reset request of a small processor subsystem into one active-high system reset. A clean power-on pulse starts a timed bring-up sequence: a short fixed bias-settle interval, followed by a power-up time-out that a 2-bit configuration input selects. The reset is then released on the first clock of a four-phase instruction cycle, never partway through one. After bring-up, other causes can pull the system back into reset: the external active-low reset pin (after a noise filter), an enabled brown-out detector, a watchdog time-out while running, a software reset request, a trap conflict and an illegal-opcode or bad-pointer event.

Each cause sets its own sticky flag in a status vector, so software can tell why the last reset happened. A flag is cleared only by a write-one-to-clear strobe, or by power-on. A watchdog time-out during sleep is a wake-up, not a reset: it only sets a flag. The reset pin is an input only, and an internally generated reset never drives it. The power-on pulse also latches the clock-source configuration field for the rest of the run.

All delays are derived from a clock-frequency parameter, so the same RTL runs at real rates or at scaled rates for simulation.

Top module: `rstc_top`

## Requirements
- R1: While `por_i` is high at a clock edge, the system reset is asserted. The status vector becomes exactly 9'h001 (only the power-on flag, bit 0, set). `clksrc_o` takes the value of `clksrc_cfg_i` and keeps it until the next power-on.
- R2: After power-on the reset stays asserted through the fixed interval of CLK_HZ/100000 cycles (at least 1), then through the power-up time-out. The time-out is 0, 4, 16 or 64 ms (times CLK_HZ/1000 cycles) for `pwrt_sel_i` = 0, 1, 2, 3, as sampled during power-on.
- R3: The system reset is released only at a Q1 edge. A 2-bit phase count is cleared by power-on and advances by one every clock. Release happens on an edge where that count is 0, so the count reads 1 just after release.
- R4: The reset pin is synchronised through SYNC_STAGES flops. It is treated as a reset request only after PIN_FILT consecutive low samples. A shorter low pulse causes no reset and sets no flag.
- R5: A filtered pin reset sets status bit 1 when `sleep_i` is low and status bit 2 when `sleep_i` is high.
- R6: `wdt_to_i` with `sleep_i` low asserts the reset on the next edge and sets status bit 3. With `sleep_i` high it leaves the reset inactive and sets status bit 4 (wake).
- R7: `bod_i` asserts the reset and sets status bit 5 only while `bod_en_i` is high. Otherwise it has no effect.
- R8: `swrst_i`, `trap_i` and `illop_i` each assert the reset on the next edge. They set status bits 6, 7 and 8 respectively.
- R9: Status flags are sticky. When `clr_wr_i` is high, each bit set in `clr_mask_i` is cleared, unless that flag's cause is active in the same cycle, in which case the set wins.
- R10: The reset is held for as long as any request is active. Once all requests are gone, it is released at the next Q1 edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on pulse; also the synchronous reset of this block |
| pin_n_i | input | 1 | External reset pin, active low, asynchronous |
| bod_i | input | 1 | Brown-out detector output |
| bod_en_i | input | 1 | Brown-out reset enable |
| wdt_to_i | input | 1 | Watchdog time-out |
| sleep_i | input | 1 | Core is in sleep |
| swrst_i | input | 1 | Software reset request |
| trap_i | input | 1 | Trap-conflict reset request |
| illop_i | input | 1 | Illegal opcode or bad pointer reset request |
| pwrt_sel_i | input | 2 | Power-up time-out select |
| clksrc_cfg_i | input | CSW | Clock-source configuration field |
| clr_wr_i | input | 1 | Status clear strobe |
| clr_mask_i | input | 9 | Bits to clear when the strobe is high |
| sys_rst_o | output | 1 | System reset, active high |
| clksrc_o | output | CSW | Clock source latched at power-on |
| status_o | output | 9 | Sticky reset-cause flags |

## Verification
The properties assume that `por_i` is high at the first clock edge and that every input other than the reset pin is synchronous to `clk`. The wake and gated brown-out properties apply only while the system is running and no other request source is active. The stimulus starts with a power-on pulse, drives one reset source at a time, and waits for the reset to be released before the next scenario. The pin is the exception: it is driven with widths just below and at the filter length.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    localparam int NFLAG      = 9;
    localparam int F_POR      = 0;
    localparam int F_PIN_RUN  = 1;
    localparam int F_PIN_SLP  = 2;
    localparam int F_WDT_RUN  = 3;
    localparam int F_WDT_WAKE = 4;
    localparam int F_BOR      = 5;
    localparam int F_SWR      = 6;
    localparam int F_TRAP     = 7;
    localparam int F_ILLOP    = 8;

    typedef enum logic [1:0] {
        SEQ_SETTLE,
        SEQ_PWRT,
        SEQ_ALIGN,
        SEQ_RUN
    } seq_state_e;

    typedef struct packed {
        logic pin;
        logic wdt;
        logic bor;
        logic swr;
        logic trap;
        logic illop;
    } rst_req_t;

    // power-up time-out in milliseconds for each select code
    function automatic int unsigned pwrt_ms(input logic [1:0] sel);
        case (sel)
            2'd0:    return 0;
            2'd1:    return 4;
            2'd2:    return 16;
            default: return 64;
        endcase
    endfunction

    // cycles in the ~10 us bias-settle interval, never zero
    function automatic int unsigned settle_cycles(input int unsigned hz);
        int unsigned c;
        c = hz / 100000;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned ms_cycles(input int unsigned hz);
        int unsigned c;
        c = hz / 1000;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/rstc_pin_filter.sv
module rstc_pin_filter #(
    parameter int FILT_LEN    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_i,
    input  logic pin_n_i,
    output logic pin_req_o
);
    localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_q;
    logic                   pin_low;

    always_ff @(posedge clk) begin
        if (por_i) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n_i};
        end
    end

    assign pin_low = ~sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (por_i) begin
            run_q     <= '0;
            pin_req_o <= 1'b0;
        end else if (!pin_low) begin
            run_q     <= '0;
            pin_req_o <= 1'b0;
        end else if (run_q == LAST) begin
            pin_req_o <= 1'b1;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

endmodule

// File: rtl/rstc_pwrup_seq.sv
module rstc_pwrup_seq
    import rstc_pkg::*;
#(
    parameter int SETTLE_CYC = 400,
    parameter int MS_CYC     = 40000
) (
    input  logic       clk,
    input  logic       por_i,
    input  logic [1:0] pwrt_sel_i,
    input  logic       req_any_i,
    output logic       sys_rst_o
);
    localparam int MAXP  = 64 * MS_CYC;
    localparam int MAXC  = (MAXP > SETTLE_CYC) ? MAXP : SETTLE_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       sel_q;
    logic [1:0]       phase_q;
    logic [CNT_W-1:0] pwrt_len;
    logic             q1;

    assign pwrt_len = CNT_W'(pwrt_ms(sel_q) * MS_CYC);
    assign q1       = (phase_q == 2'd0);

    // free-running four-phase instruction cycle counter
    always_ff @(posedge clk) begin
        if (por_i) phase_q <= 2'd0;
        else       phase_q <= phase_q + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (por_i) begin
            state_q <= SEQ_SETTLE;
            cnt_q   <= '0;
            sel_q   <= pwrt_sel_i;
        end else begin
            case (state_q)
                SEQ_SETTLE: begin
                    if (cnt_q == SETTLE_LAST) begin
                        cnt_q   <= '0;
                        state_q <= (pwrt_len == '0) ? SEQ_ALIGN : SEQ_PWRT;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SEQ_PWRT: begin
                    if (cnt_q == pwrt_len - 1'b1) begin
                        cnt_q   <= '0;
                        state_q <= SEQ_ALIGN;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SEQ_ALIGN: begin
                    if (!req_any_i && q1) state_q <= SEQ_RUN;
                end
                default: begin
                    if (req_any_i) state_q <= SEQ_ALIGN;
                end
            endcase
        end
    end

    assign sys_rst_o = (state_q != SEQ_RUN);

endmodule

// File: rtl/rstc_status.sv
module rstc_status
    import rstc_pkg::*;
(
    input  logic             clk,
    input  logic             por_i,
    input  logic [NFLAG-1:0] set_i,
    input  logic             clr_wr_i,
    input  logic [NFLAG-1:0] clr_mask_i,
    output logic [NFLAG-1:0] flags_o
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (por_i) begin
                flags_o[i] <= (i == F_POR);
            end else if (set_i[i]) begin
                flags_o[i] <= 1'b1;
            end else if (clr_wr_i && clr_mask_i[i]) begin
                flags_o[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rstc_top.sv
module rstc_top
    import rstc_pkg::*;
#(
    parameter int CLK_HZ      = 40_000_000,
    parameter int PIN_FILT    = 4,
    parameter int SYNC_STAGES = 2,
    parameter int CSW         = 3
) (
    input  logic             clk,
    input  logic             por_i,
    input  logic             pin_n_i,
    input  logic             bod_i,
    input  logic             bod_en_i,
    input  logic             wdt_to_i,
    input  logic             sleep_i,
    input  logic             swrst_i,
    input  logic             trap_i,
    input  logic             illop_i,
    input  logic [1:0]       pwrt_sel_i,
    input  logic [CSW-1:0]   clksrc_cfg_i,
    input  logic             clr_wr_i,
    input  logic [NFLAG-1:0] clr_mask_i,
    output logic             sys_rst_o,
    output logic [CSW-1:0]   clksrc_o,
    output logic [NFLAG-1:0] status_o
);
    localparam int SETTLE_CYC = settle_cycles(CLK_HZ);
    localparam int MS_CYC     = ms_cycles(CLK_HZ);

    logic             pin_req;
    rst_req_t         req;
    logic             req_any;
    logic [NFLAG-1:0] set_v;

    rstc_pin_filter #(
        .FILT_LEN    (PIN_FILT),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_filt (
        .clk       (clk),
        .por_i     (por_i),
        .pin_n_i   (pin_n_i),
        .pin_req_o (pin_req)
    );

    always_comb begin
        req.pin   = pin_req;
        req.wdt   = wdt_to_i & ~sleep_i;
        req.bor   = bod_i & bod_en_i;
        req.swr   = swrst_i;
        req.trap  = trap_i;
        req.illop = illop_i;
    end

    assign req_any = |req;

    always_comb begin
        set_v             = '0;
        set_v[F_PIN_RUN]  = req.pin & ~sleep_i;
        set_v[F_PIN_SLP]  = req.pin & sleep_i;
        set_v[F_WDT_RUN]  = req.wdt;
        set_v[F_WDT_WAKE] = wdt_to_i & sleep_i;
        set_v[F_BOR]      = req.bor;
        set_v[F_SWR]      = req.swr;
        set_v[F_TRAP]     = req.trap;
        set_v[F_ILLOP]    = req.illop;
    end

    rstc_pwrup_seq #(
        .SETTLE_CYC (SETTLE_CYC),
        .MS_CYC     (MS_CYC)
    ) u_seq (
        .clk        (clk),
        .por_i      (por_i),
        .pwrt_sel_i (pwrt_sel_i),
        .req_any_i  (req_any),
        .sys_rst_o  (sys_rst_o)
    );

    rstc_status u_stat (
        .clk        (clk),
        .por_i      (por_i),
        .set_i      (set_v),
        .clr_wr_i   (clr_wr_i),
        .clr_mask_i (clr_mask_i),
        .flags_o    (status_o)
    );

    always_ff @(posedge clk) begin
        if (por_i) clksrc_o <= clksrc_cfg_i;
    end

endmodule

// File: rtl/rstc_chk.sv
module rstc_chk
    import rstc_pkg::*;
#(
    parameter int FILT_LEN = 4
) (
    input logic             clk,
    input logic             por_i,
    input logic             pin_n_i,
    input logic             bod_i,
    input logic             bod_en_i,
    input logic             wdt_to_i,
    input logic             sleep_i,
    input logic             swrst_i,
    input logic             trap_i,
    input logic             illop_i,
    input logic             clr_wr_i,
    input logic             sys_rst_o,
    input logic [NFLAG-1:0] status_o,
    input logic             pin_req
);
    logic [1:0]  ph_m;
    logic [15:0] run_q;
    logic [15:0] last_q;
    logic        others_wake;
    logic        others_bor;

    always_ff @(posedge clk) begin
        if (por_i) ph_m <= 2'd0;
        else       ph_m <= ph_m + 2'd1;
    end

    // length of the current and the last completed low stretch on the pin
    always_ff @(posedge clk) begin
        if (por_i) begin
            run_q  <= '0;
            last_q <= '0;
        end else if (!pin_n_i) begin
            if (run_q != 16'hFFFF) run_q <= run_q + 16'd1;
        end else begin
            if (run_q != '0) last_q <= run_q;
            run_q <= '0;
        end
    end

    assign others_wake = pin_req | (bod_i & bod_en_i) | swrst_i | trap_i | illop_i;
    assign others_bor  = pin_req | wdt_to_i | swrst_i | trap_i | illop_i;

    p_por_state_r1: assert property (@(posedge clk)
        por_i |=> (sys_rst_o && status_o == NFLAG'(1)));

    p_q1_release_r3: assert property (@(posedge clk) disable iff (por_i)
        $fell(sys_rst_o) |-> (ph_m == 2'd1));

    p_filter_len_r4: assert property (@(posedge clk) disable iff (por_i)
        $rose(pin_req) |-> (run_q >= 16'(FILT_LEN) || last_q >= 16'(FILT_LEN)));

    p_wake_no_reset_r6: assert property (@(posedge clk) disable iff (por_i)
        (!sys_rst_o && wdt_to_i && sleep_i && !others_wake)
        |=> (!sys_rst_o && status_o[F_WDT_WAKE]));

    p_bor_gated_r7: assert property (@(posedge clk) disable iff (por_i)
        (!sys_rst_o && bod_i && !bod_en_i && !others_bor) |=> !sys_rst_o);

    p_bor_hold_r10: assert property (@(posedge clk) disable iff (por_i)
        (bod_i && bod_en_i) |=> (sys_rst_o && status_o[F_BOR]));

    p_sw_reset_r8: assert property (@(posedge clk) disable iff (por_i)
        swrst_i |=> (sys_rst_o && status_o[F_SWR]));

    p_sticky_r9: assert property (@(posedge clk) disable iff (por_i)
        !clr_wr_i |=> ((status_o & $past(status_o)) == $past(status_o)));

endmodule

bind rstc_top rstc_chk #(.FILT_LEN(PIN_FILT)) u_chk (
    .clk       (clk),
    .por_i     (por_i),
    .pin_n_i   (pin_n_i),
    .bod_i     (bod_i),
    .bod_en_i  (bod_en_i),
    .wdt_to_i  (wdt_to_i),
    .sleep_i   (sleep_i),
    .swrst_i   (swrst_i),
    .trap_i    (trap_i),
    .illop_i   (illop_i),
    .clr_wr_i  (clr_wr_i),
    .sys_rst_o (sys_rst_o),
    .status_o  (status_o),
    .pin_req   (pin_req)
);

// File: tb/rstc_top_tb.sv
module rstc_top_tb;
    localparam int CLK_HZ = 400_000;
    localparam int FILT   = 4;
    localparam int CSW    = 3;
    localparam int SETTLE = CLK_HZ / 100000;
    localparam int MSC    = CLK_HZ / 1000;

    logic           clk = 1'b0;
    logic           por_i = 1'b1;
    logic           pin_n_i = 1'b1;
    logic           bod_i = 1'b0, bod_en_i = 1'b0, wdt_to_i = 1'b0, sleep_i = 1'b0;
    logic           swrst_i = 1'b0, trap_i = 1'b0, illop_i = 1'b0;
    logic [1:0]     pwrt_sel_i = 2'd0;
    logic [CSW-1:0] clksrc_cfg_i = '0;
    logic           clr_wr_i = 1'b0;
    logic [8:0]     clr_mask_i = '0;
    logic           sys_rst_o;
    logic [CSW-1:0] clksrc_o;
    logic [8:0]     status_o;

    int  errors = 0;
    int  checks = 0;
    logic [1:0] bph = 2'd0;
    logic prev_rst = 1'b1;

    always #2 clk = ~clk;

    rstc_top #(.CLK_HZ(CLK_HZ), .PIN_FILT(FILT), .SYNC_STAGES(2), .CSW(CSW)) u_dut (
        .clk(clk), .por_i(por_i), .pin_n_i(pin_n_i), .bod_i(bod_i), .bod_en_i(bod_en_i),
        .wdt_to_i(wdt_to_i), .sleep_i(sleep_i), .swrst_i(swrst_i), .trap_i(trap_i),
        .illop_i(illop_i), .pwrt_sel_i(pwrt_sel_i), .clksrc_cfg_i(clksrc_cfg_i),
        .clr_wr_i(clr_wr_i), .clr_mask_i(clr_mask_i), .sys_rst_o(sys_rst_o),
        .clksrc_o(clksrc_o), .status_o(status_o)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // model of the four-phase count (R3)
    always @(posedge clk) bph <= por_i ? 2'd0 : bph + 2'd1;

    always @(negedge clk) begin
        if (!por_i && prev_rst === 1'b1 && sys_rst_o === 1'b0)
            chk(bph == 2'd1, "R3", "phase at release", bph, 1);
        prev_rst = sys_rst_o;
    end

    task automatic wait_rel();
        while (sys_rst_o) @(negedge clk);
    endtask

    task automatic clear_all();
        @(negedge clk); clr_wr_i = 1'b1; clr_mask_i = 9'h1FF;
        @(negedge clk); clr_wr_i = 1'b0; clr_mask_i = '0;
    endtask

    task automatic t_por(input logic [1:0] sel, input logic [CSW-1:0] cfg);
        int m;
        int exp_m;
        @(negedge clk); pwrt_sel_i = sel; clksrc_cfg_i = cfg; por_i = 1'b1;
        @(negedge clk); por_i = 1'b0;
        chk(sys_rst_o == 1'b1, "R1", "reset during power-on", sys_rst_o, 1);
        chk(status_o == 9'h001, "R1", "status after power-on", status_o, 1);
        chk(clksrc_o == cfg, "R1", "clock source latched", clksrc_o, cfg);
        clksrc_cfg_i = ~cfg;
        pwrt_sel_i = ~sel;
        m = 0;
        while (sys_rst_o) begin
            @(posedge clk); m++;
            @(negedge clk);
        end
        exp_m = SETTLE + ((sel == 0) ? 0 : (sel == 1) ? 4 : (sel == 2) ? 16 : 64) * MSC + 1;
        while (exp_m % 4 != 1) exp_m++;
        chk(m == exp_m, "R2", "edges to release", m, exp_m);
        chk(clksrc_o == cfg, "R1", "clock source held", clksrc_o, cfg);
    endtask

    task automatic t_pin(input int len, input logic slp);
        bit saw;
        saw = 0;
        clear_all();
        @(negedge clk); sleep_i = slp; pin_n_i = 1'b0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk); if (sys_rst_o) saw = 1;
        end
        pin_n_i = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); if (sys_rst_o) saw = 1;
        end
        if (len < FILT) begin
            chk(saw == 0, "R4", "short pulse reset", saw, 0);
            chk(status_o == 9'h000, "R4", "short pulse flags", status_o, 0);
        end else begin
            chk(saw == 1, "R4", "long pulse reset", saw, 1);
            chk(status_o == (slp ? 9'h004 : 9'h002), "R5", "pin flag",
                status_o, slp ? 4 : 2);
        end
        sleep_i = 1'b0;
        wait_rel();
    endtask

    task automatic t_wdt(input logic slp);
        clear_all();
        @(negedge clk); sleep_i = slp; wdt_to_i = 1'b1;
        @(negedge clk); wdt_to_i = 1'b0;
        chk(sys_rst_o == !slp, "R6", "reset after watchdog", sys_rst_o, !slp);
        chk(status_o == (slp ? 9'h010 : 9'h008), "R6", "watchdog flag",
            status_o, slp ? 16 : 8);
        sleep_i = 1'b0;
        repeat (3) @(negedge clk);
        if (slp) chk(sys_rst_o == 1'b0, "R6", "still running after wake", sys_rst_o, 0);
        wait_rel();
    endtask

    task automatic t_bor(input logic en);
        bit bad;
        int rel;
        bad = 0;
        clear_all();
        @(negedge clk); bod_en_i = en; bod_i = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); if (sys_rst_o != en) bad = 1;
        end
        bod_i = 1'b0;
        chk(bad == 0, en ? "R10" : "R7", "reset while brown-out", bad, 0);
        chk(status_o[5] == en, "R7", "brown-out flag", status_o[5], en);
        rel = 0;
        while (sys_rst_o) begin @(negedge clk); rel++; end
        if (en) chk(rel >= 1 && rel <= 4, "R10", "cycles to release", rel, 4);
        bod_en_i = 1'b0;
    endtask

    task automatic t_pulse(input int kind);
        clear_all();
        @(negedge clk);
        case (kind)
            0: swrst_i = 1'b1;
            1: trap_i  = 1'b1;
            default: illop_i = 1'b1;
        endcase
        @(negedge clk); swrst_i = 1'b0; trap_i = 1'b0; illop_i = 1'b0;
        chk(sys_rst_o == 1'b1, "R8", "reset after request", sys_rst_o, 1);
        chk(status_o == (9'h040 << kind), "R8", "request flag", status_o, 64 << kind);
        wait_rel();
    endtask

    task automatic t_clear();
        clear_all();
        @(negedge clk); swrst_i = 1'b1;
        @(negedge clk); swrst_i = 1'b0; trap_i = 1'b1;
        @(negedge clk); trap_i = 1'b0;
        wait_rel();
        repeat (5) @(negedge clk);
        chk(status_o == 9'h0C0, "R9", "flags sticky", status_o, 9'h0C0);
        clr_wr_i = 1'b1; clr_mask_i = 9'h080;
        @(negedge clk); clr_wr_i = 1'b0; clr_mask_i = '0;
        chk(status_o == 9'h040, "R9", "masked clear", status_o, 9'h040);
        swrst_i = 1'b1; clr_wr_i = 1'b1; clr_mask_i = 9'h040;
        @(negedge clk); swrst_i = 1'b0; clr_wr_i = 1'b0; clr_mask_i = '0;
        chk(status_o == 9'h040, "R9", "set wins over clear", status_o, 9'h040);
        wait_rel();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        por_i = 1'b0;
        wait_rel();
        t_por(2'd0, 3'b101);
        t_por(2'd1, 3'b010);
        t_por(2'd2, 3'b110);
        t_por(2'd3, 3'b001);
        t_pin(FILT - 1, 1'b0);
        t_pin(FILT, 1'b0);
        t_pin(FILT + 3, 1'b1);
        t_wdt(1'b0);
        t_wdt(1'b1);
        t_bor(1'b0);
        t_bor(1'b1);
        t_pulse(0);
        t_pulse(1);
        t_pulse(2);
        t_clear();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule